// File: doc/BRIEF.md
# Host Memory Atomic Read-Modify-Write Engine

This block lets an agent issue atomic operations against host memory that is reached through a port offering only plain reads and writes. An atomic request becomes three steps in a fixed sequence. First the engine reads the target location. Next it computes the new value from a copy of the read data and the request operands. Last it writes the result back to the same address with the same size. The requester gets back the value that was in memory before the operation. It gets that value only after the write-back has been acknowledged, so a response always means the memory already holds the new value.

Plain reads and writes pass through as a single memory access each, and each completes on its memory response. The engine takes one request at a time and holds off new requests until the current response has been handed over. Ordering between requests to the same address is left to the logic upstream. The data path is 64 bits wide by default. A request marked narrow works on the lower 32 bits only, in little-endian lane order.

Top module: `hostmem_rmw_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, and both `rsp_valid` and `mem_req_valid` are 0.
- R2: Only one request is in flight at a time. `req_ready` goes low in the cycle after a request is accepted. It stays low while `rsp_valid` is high, and returns only after the response handshake (`rsp_valid` and `rsp_ready` both high at a clock edge).
- R3: A request with `req_kind` = 2'b00 (read) causes exactly one memory read (`mem_req_we` = 0) of the same address and size. Its response carries the read data and is raised only after the memory response arrives.
- R4: A request with `req_kind` = 2'b01 (write) causes exactly one memory write of `req_opa` to the same address and size, and no memory read. Its response is raised after the write acknowledgement and carries all-zero data.
- R5: A request with `req_kind[1]` = 1 (atomic) first causes one memory read and then one memory write to the same address and size. Its response carries the value read before the operation, and `rsp_valid` rises only in the cycle after the write-back acknowledgement.
- R6: Atomic codes (`req_op`) 0 = add (wraps around at the operand width), 1 = swap (writes `req_opa`), 3 = AND, 4 = OR, 5 = XOR. For add and the three logic codes the operands are the read value and `req_opa`.
- R7: Atomic code 2 = compare-and-swap. It writes `req_opa` when the read value equals `req_opb`; otherwise it writes the read value back unchanged.
- R8: Atomic codes 6 = signed min, 7 = unsigned min, 8 = signed max, 9 = unsigned max. Each writes the smaller or larger of the read value and `req_opa`.
- R9: When `req_wide` = 0, reads, writes and atomics use only bits 31:0 of the read data and operands. `mem_req_wide` is 0, bits 63:32 of `mem_req_wdata` are 0, and bits 63:32 of `rsp_data` are 0.
- R10: Atomic codes 10 to 15 write the read value back unchanged and still return it.
- R11: Once raised, `mem_req_valid` and its address, direction and write data hold steady until `mem_req_ready`. Once raised, `rsp_valid` and `rsp_data` hold steady until `rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request accepted at this edge if valid |
| req_kind | input | 2 | 00 read, 01 write, 1x atomic |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access (forced 0 for a 32-bit data path) |
| req_op | input | 4 | Atomic operation code |
| req_addr | input | ADDR_W | Target address |
| req_opa | input | DATA_W | Write data, or atomic source or swap operand |
| req_opb | input | DATA_W | Compare operand for compare-and-swap |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | DATA_W | Read data, prior value for atomics, zero for writes |
| mem_req_valid | output | 1 | Memory access present |
| mem_req_ready | input | 1 | Memory takes the access |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_wide | output | 1 | Access size, 1 = 64-bit, 0 = 32-bit |
| mem_req_addr | output | ADDR_W | Memory address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_rsp_valid | input | 1 | Memory read data or write acknowledgement, one per access |
| mem_rsp_data | input | DATA_W | Memory read data |

## Verification
The hardest case to reach is an atomic that is stalled at every handshake. Its read, its write-back and its response each wait several cycles. During those waits the bench must confirm that nothing moves and that the response does not appear before the write acknowledgement. The bench memory and the requester drop their ready signals in a pattern taken from a shift register, so stalls of different lengths land on every stage. The bench keeps its own copy of memory and takes the compare operand from that copy to force compare-and-swap matches. Narrow matches where only the upper half differs come from words whose halves hold different patterns.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SWAP = 4'd1,
      OP_CAS  = 4'd2,
      OP_AND  = 4'd3,
      OP_OR   = 4'd4,
      OP_XOR  = 4'd5,
      OP_SMIN = 4'd6,
      OP_UMIN = 4'd7,
      OP_SMAX = 4'd8,
      OP_UMAX = 4'd9
   } rmw_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_REQ,
      ST_RD_WAIT,
      ST_CALC,
      ST_WR_REQ,
      ST_WR_WAIT,
      ST_RESP
   } rmw_state_e;

   localparam int NARROW_W = 32;

   function automatic logic kind_is_atomic(input logic [1:0] kind);
      return kind[1];
   endfunction

   function automatic logic kind_is_write(input logic [1:0] kind);
      return !kind[1] && kind[0];
   endfunction

endpackage

// File: rtl/rmw_size_mask.sv
module rmw_size_mask #(
   parameter int DATA_W = 64
) (
   input  logic              wide,
   input  logic [DATA_W-1:0] in_v,
   output logic [DATA_W-1:0] out_v
);
   localparam int NW = rmw_pkg::NARROW_W;

   generate
      if (DATA_W > NW) begin : g_split
         assign out_v = wide ? in_v : {{(DATA_W-NW){1'b0}}, in_v[NW-1:0]};
      end else begin : g_flat
         logic unused_wide;
         assign unused_wide = wide;
         assign out_v = in_v;
      end
   endgenerate
endmodule

// File: rtl/rmw_alu_lane.sv
module rmw_alu_lane #(
   parameter int W = 32
) (
   input  logic [3:0]   op,
   input  logic [W-1:0] old_v,
   input  logic [W-1:0] a_v,
   input  logic [W-1:0] b_v,
   output logic [W-1:0] new_v
);
   import rmw_pkg::*;

   logic s_lt;
   logic u_lt;

   assign s_lt = $signed(a_v) < $signed(old_v);
   assign u_lt = a_v < old_v;

   always_comb begin
      new_v = old_v;
      case (op)
         OP_ADD:  new_v = old_v + a_v;
         OP_SWAP: new_v = a_v;
         OP_CAS:  new_v = (old_v == b_v) ? a_v : old_v;
         OP_AND:  new_v = old_v & a_v;
         OP_OR:   new_v = old_v | a_v;
         OP_XOR:  new_v = old_v ^ a_v;
         OP_SMIN: new_v = s_lt ? a_v : old_v;
         OP_UMIN: new_v = u_lt ? a_v : old_v;
         OP_SMAX: new_v = s_lt ? old_v : a_v;
         OP_UMAX: new_v = u_lt ? old_v : a_v;
         default: new_v = old_v;
      endcase
   end
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu #(
   parameter int DATA_W = 64
) (
   input  logic [3:0]        op,
   input  logic              wide,
   input  logic [DATA_W-1:0] old_v,
   input  logic [DATA_W-1:0] a_v,
   input  logic [DATA_W-1:0] b_v,
   output logic [DATA_W-1:0] res_v
);
   localparam int NW = rmw_pkg::NARROW_W;

   logic [NW-1:0] res_n;

   rmw_alu_lane #(.W(NW)) u_lane_n (
      .op    (op),
      .old_v (old_v[NW-1:0]),
      .a_v   (a_v[NW-1:0]),
      .b_v   (b_v[NW-1:0]),
      .new_v (res_n)
   );

   generate
      if (DATA_W > NW) begin : g_wide
         logic [DATA_W-1:0] res_w;
         rmw_alu_lane #(.W(DATA_W)) u_lane_w (
            .op    (op),
            .old_v (old_v),
            .a_v   (a_v),
            .b_v   (b_v),
            .new_v (res_w)
         );
         assign res_v = wide ? res_w : {{(DATA_W-NW){1'b0}}, res_n};
      end else begin : g_narrow
         logic unused_wide;
         assign unused_wide = wide;
         assign res_v = res_n;
      end
   endgenerate
endmodule

// File: rtl/rmw_seq.sv
module rmw_seq #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic              req_wide,
   input  logic [3:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_opa,
   input  logic [DATA_W-1:0] req_opb,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [DATA_W-1:0] rsp_data,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_we,
   output logic              mem_req_wide,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output logic [3:0]        alu_op,
   output logic              alu_wide,
   output logic [DATA_W-1:0] alu_old,
   output logic [DATA_W-1:0] alu_a,
   output logic [DATA_W-1:0] alu_b,
   input  logic [DATA_W-1:0] alu_res
);
   import rmw_pkg::*;

   localparam int NW = NARROW_W;

   rmw_state_e        state;
   logic [ADDR_W-1:0] addr_q;
   logic              wide_q;
   logic              atom_q;
   logic [3:0]        op_q;
   logic [DATA_W-1:0] opa_q;
   logic [DATA_W-1:0] opb_q;
   logic [DATA_W-1:0] old_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rsp_q;

   logic              wide_in;
   logic [DATA_W-1:0] opa_m;
   logic [DATA_W-1:0] opb_m;
   logic [DATA_W-1:0] rd_m;

   assign wide_in = (DATA_W > NW) ? req_wide : 1'b0;

   rmw_size_mask #(.DATA_W(DATA_W)) u_mask_a (
      .wide (wide_in), .in_v (req_opa), .out_v (opa_m)
   );
   rmw_size_mask #(.DATA_W(DATA_W)) u_mask_b (
      .wide (wide_in), .in_v (req_opb), .out_v (opb_m)
   );
   rmw_size_mask #(.DATA_W(DATA_W)) u_mask_rd (
      .wide (wide_q), .in_v (mem_rsp_data), .out_v (rd_m)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         addr_q  <= '0;
         wide_q  <= 1'b0;
         atom_q  <= 1'b0;
         op_q    <= '0;
         opa_q   <= '0;
         opb_q   <= '0;
         old_q   <= '0;
         wdata_q <= '0;
         rsp_q   <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  addr_q  <= req_addr;
                  wide_q  <= wide_in;
                  atom_q  <= kind_is_atomic(req_kind);
                  op_q    <= req_op;
                  opa_q   <= opa_m;
                  opb_q   <= opb_m;
                  wdata_q <= opa_m;
                  state   <= kind_is_write(req_kind) ? ST_WR_REQ : ST_RD_REQ;
               end
            end
            ST_RD_REQ: begin
               if (mem_req_ready) state <= ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
               if (mem_rsp_valid) begin
                  old_q <= rd_m;
                  rsp_q <= rd_m;
                  state <= atom_q ? ST_CALC : ST_RESP;
               end
            end
            ST_CALC: begin
               wdata_q <= alu_res;
               state   <= ST_WR_REQ;
            end
            ST_WR_REQ: begin
               if (mem_req_ready) state <= ST_WR_WAIT;
            end
            ST_WR_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!atom_q) rsp_q <= '0;
                  state <= ST_RESP;
               end
            end
            ST_RESP: begin
               if (rsp_ready) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (state == ST_IDLE);
   assign rsp_valid     = (state == ST_RESP);
   assign rsp_data      = rsp_q;
   assign mem_req_valid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
   assign mem_req_we    = (state == ST_WR_REQ);
   assign mem_req_wide  = wide_q;
   assign mem_req_addr  = addr_q;
   assign mem_req_wdata = wdata_q;

   assign alu_op   = op_q;
   assign alu_wide = wide_q;
   assign alu_old  = old_q;
   assign alu_a    = opa_q;
   assign alu_b    = opb_q;

   // R2: no second acceptance right after one
   p_single_inflight_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R2: requester never sees ready while a response waits
   p_no_accept_during_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   // R11: memory access held until taken
   p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
         && $stable(mem_req_we) && $stable(mem_req_wdata)));

   // R11: response held until taken
   p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

   // R5: a response only follows a memory completion
   p_rsp_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) |-> $past(mem_rsp_valid));

   generate
      if (DATA_W > NW) begin : g_rsp_chk
         // R9: narrow responses carry nothing in the upper half
         p_narrow_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_valid && !mem_req_wide) |-> (rsp_data[DATA_W-1:NW] == '0));
      end
   endgenerate
endmodule

// File: rtl/hostmem_rmw_engine.sv
module hostmem_rmw_engine #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic              req_wide,
   input  logic [3:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_opa,
   input  logic [DATA_W-1:0] req_opb,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [DATA_W-1:0] rsp_data,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_we,
   output logic              mem_req_wide,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data
);
   localparam int NW = rmw_pkg::NARROW_W;

   generate
      if (DATA_W != 32 && DATA_W != 64) begin : g_bad_data_w
         $error("hostmem_rmw_engine: DATA_W must be 32 or 64");
      end
      if (ADDR_W < 4) begin : g_bad_addr_w
         $error("hostmem_rmw_engine: ADDR_W must be at least 4");
      end
   endgenerate

   logic [3:0]        alu_op;
   logic              alu_wide;
   logic [DATA_W-1:0] alu_old;
   logic [DATA_W-1:0] alu_a;
   logic [DATA_W-1:0] alu_b;
   logic [DATA_W-1:0] alu_res;

   rmw_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_kind      (req_kind),
      .req_wide      (req_wide),
      .req_op        (req_op),
      .req_addr      (req_addr),
      .req_opa       (req_opa),
      .req_opb       (req_opb),
      .rsp_valid     (rsp_valid),
      .rsp_ready     (rsp_ready),
      .rsp_data      (rsp_data),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_we    (mem_req_we),
      .mem_req_wide  (mem_req_wide),
      .mem_req_addr  (mem_req_addr),
      .mem_req_wdata (mem_req_wdata),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .alu_op        (alu_op),
      .alu_wide      (alu_wide),
      .alu_old       (alu_old),
      .alu_a         (alu_a),
      .alu_b         (alu_b),
      .alu_res       (alu_res)
   );

   rmw_alu #(.DATA_W(DATA_W)) u_alu (
      .op    (alu_op),
      .wide  (alu_wide),
      .old_v (alu_old),
      .a_v   (alu_a),
      .b_v   (alu_b),
      .res_v (alu_res)
   );

   generate
      if (DATA_W > NW) begin : g_port_chk
         // R9: narrow memory writes leave the upper lane at zero
         p_narrow_wdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_req_valid && mem_req_we && !mem_req_wide)
               |-> (mem_req_wdata[DATA_W-1:NW] == '0));
      end
   endgenerate
endmodule

// File: tb/tb_hostmem_rmw_engine.sv
module tb_hostmem_rmw_engine;
   localparam int AW = 32;
   localparam int DW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_kind = '0;
   logic          req_wide = 1'b0;
   logic [3:0]    req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_opa = '0;
   logic [DW-1:0] req_opb = '0;
   logic          rsp_valid;
   logic          rsp_ready;
   logic [DW-1:0] rsp_data;
   logic          mem_req_valid;
   logic          mem_req_ready;
   logic          mem_req_we;
   logic          mem_req_wide;
   logic [AW-1:0] mem_req_addr;
   logic [DW-1:0] mem_req_wdata;
   logic          mem_rsp_valid;
   logic [DW-1:0] mem_rsp_data;

   always #10 clk = ~clk;

   hostmem_rmw_engine #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

   int errors = 0;
   int checks = 0;

   function automatic logic [63:0] init_word(input int i);
      return 64'h8000_0001_7FFF_FFF0 + 64'(i) * 64'h0123_4567_0000_0011;
   endfunction

   // ---------------- memory model with stalls ----------------
   logic [63:0] mem [8];
   logic [7:0]  lfsr;
   logic        pend;
   logic [2:0]  pcnt;
   logic [63:0] pdata;
   int          n_rd;
   int          n_wr;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) mem[i] <= init_word(i);
         lfsr <= 8'h5B; pend <= 1'b0; pcnt <= '0; pdata <= '0;
         mem_req_ready <= 1'b0; mem_rsp_valid <= 1'b0; mem_rsp_data <= '0;
         rsp_ready <= 1'b0; n_rd <= 0; n_wr <= 0;
      end else begin
         lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         mem_req_ready <= lfsr[0] | lfsr[2];
         rsp_ready     <= lfsr[3] | lfsr[6];
         mem_rsp_valid <= 1'b0;
         if (mem_req_valid && mem_req_ready) begin
            pend <= 1'b1;
            pcnt <= {1'b0, lfsr[2:1]};
            if (mem_req_we) begin
               n_wr <= n_wr + 1;
               pdata <= 64'hDEAD_BEEF_DEAD_BEEF;
               if (mem_req_wide) mem[mem_req_addr[5:3]] <= mem_req_wdata;
               else mem[mem_req_addr[5:3]][31:0] <= mem_req_wdata[31:0];
            end else begin
               n_rd <= n_rd + 1;
               pdata <= mem[mem_req_addr[5:3]];
            end
         end
         if (pend) begin
            if (pcnt == 0) begin
               mem_rsp_valid <= 1'b1;
               mem_rsp_data  <= pdata;
               pend <= 1'b0;
            end else begin
               pcnt <= pcnt - 1;
            end
         end
      end
   end

   // ---------------- scoreboard ----------------
   typedef struct packed {
      logic [63:0] data;
      logic [2:0]  idx;
      logic [63:0] word;
      logic [1:0]  rd;
      logic [1:0]  wr;
   } exp_t;

   exp_t        exp_q [$];
   string       tag_q [$];
   logic [63:0] shadow [8];

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [63:0] apply_op(input logic [3:0] op, input logic wide,
                                            input logic [63:0] o, input logic [63:0] a,
                                            input logic [63:0] b);
      logic [31:0] o32, a32, b32, r32;
      if (wide) begin
         if (op == 4'd0) return o + a;
         else if (op == 4'd1) return a;
         else if (op == 4'd2) return (o == b) ? a : o;
         else if (op == 4'd3) return o & a;
         else if (op == 4'd4) return o | a;
         else if (op == 4'd5) return o ^ a;
         else if (op == 4'd6) return ($signed(a) < $signed(o)) ? a : o;
         else if (op == 4'd7) return (a < o) ? a : o;
         else if (op == 4'd8) return ($signed(a) > $signed(o)) ? a : o;
         else if (op == 4'd9) return (a > o) ? a : o;
         else return o;
      end
      o32 = o[31:0]; a32 = a[31:0]; b32 = b[31:0];
      if (op == 4'd0) r32 = o32 + a32;
      else if (op == 4'd1) r32 = a32;
      else if (op == 4'd2) r32 = (o32 == b32) ? a32 : o32;
      else if (op == 4'd3) r32 = o32 & a32;
      else if (op == 4'd4) r32 = o32 | a32;
      else if (op == 4'd5) r32 = o32 ^ a32;
      else if (op == 4'd6) r32 = ($signed(a32) < $signed(o32)) ? a32 : o32;
      else if (op == 4'd7) r32 = (a32 < o32) ? a32 : o32;
      else if (op == 4'd8) r32 = ($signed(a32) > $signed(o32)) ? a32 : o32;
      else if (op == 4'd9) r32 = (a32 > o32) ? a32 : o32;
      else r32 = o32;
      return {32'h0, r32};
   endfunction

   task automatic issue(input logic [1:0] kind, input logic wide, input logic [3:0] op,
                        input int idx, input logic [63:0] a, input logic [63:0] b,
                        input string tag);
      exp_t        e;
      logic [63:0] old, res;
      old    = shadow[idx];
      e.idx  = 3'(idx);
      if (kind[1]) begin
         res    = apply_op(op, wide, old, a, b);
         e.data = wide ? old : {32'h0, old[31:0]};
         e.word = wide ? res : {old[63:32], res[31:0]};
         e.rd   = 2'd1; e.wr = 2'd1;
      end else if (kind[0]) begin
         e.data = '0;
         e.word = wide ? a : {old[63:32], a[31:0]};
         e.rd   = 2'd0; e.wr = 2'd1;
      end else begin
         e.data = wide ? old : {32'h0, old[31:0]};
         e.word = old;
         e.rd   = 2'd1; e.wr = 2'd0;
      end
      shadow[idx] = e.word;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      req_valid = 1'b1; req_kind = kind; req_wide = wide; req_op = op;
      req_addr = AW'(idx * 8 + 32'h4000); req_opa = a; req_opb = b;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // monitor
   int          last_rd = 0;
   int          last_wr = 0;
   logic        hold_pend = 1'b0;
   logic [63:0] hold_data = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (hold_pend) begin
            check(rsp_valid && rsp_data == hold_data, "R11", "response held",
                  rsp_data, hold_data);
         end
         hold_pend = rsp_valid && !rsp_ready;
         hold_data = rsp_data;
         if (rsp_valid) begin
            check(!req_ready, "R2", "ready low while response waits",
                  64'(req_ready), 64'h0);
         end
         if (rsp_valid && rsp_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R2", "unexpected response", rsp_data, 64'h0);
            end else begin
               exp_t  e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(rsp_data == e.data, t, "rsp_data", rsp_data, e.data);
               check(mem[e.idx] == e.word, t, "memory word", mem[e.idx], e.word);
               check((n_rd - last_rd) == int'(e.rd) && (n_wr - last_wr) == int'(e.wr),
                     t, "memory reads/writes",
                     64'((n_rd - last_rd) * 16 + (n_wr - last_wr)),
                     64'(int'(e.rd) * 16 + int'(e.wr)));
               last_rd = n_rd;
               last_wr = n_wr;
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R2 actual=hung expected=all responses");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) shadow[i] = init_word(i);
      repeat (3) @(negedge clk);
      // R1: reset values
      check(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R1",
            "reset outputs", {61'h0, req_ready, rsp_valid, mem_req_valid}, 64'h4);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R1",
            "after reset", {61'h0, req_ready, rsp_valid, mem_req_valid}, 64'h4);

      issue(2'b00, 1'b1, 4'd0, 0, 64'h0, 64'h0, "R3 wide read");
      issue(2'b00, 1'b0, 4'd0, 1, 64'h0, 64'h0, "R9 narrow read");
      issue(2'b01, 1'b1, 4'd0, 2, 64'h1122_3344_5566_7788, 64'h0, "R4 wide write");
      issue(2'b01, 1'b0, 4'd0, 3, 64'hFFFF_FFFF_0BAD_F00D, 64'h0, "R9 narrow write");
      issue(2'b10, 1'b1, 4'd0, 4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R6 add wraps");
      issue(2'b10, 1'b0, 4'd0, 0, 64'h7777_7777_9000_0000, 64'h0, "R9 narrow add");
      issue(2'b10, 1'b1, 4'd1, 5, 64'hCAFE_0000_1234_5678, 64'h0, "R6 swap");
      issue(2'b10, 1'b1, 4'd3, 6, 64'h0F0F_F0F0_00FF_FF00, 64'h0, "R6 and");
      issue(2'b10, 1'b1, 4'd4, 7, 64'h8000_0000_0000_0001, 64'h0, "R6 or");
      issue(2'b10, 1'b0, 4'd5, 1, 64'hAAAA_AAAA_5555_5555, 64'h0, "R6 narrow xor");
      issue(2'b10, 1'b1, 4'd2, 2, 64'h0000_0000_CAFE_CAFE, shadow[2], "R7 cas match");
      issue(2'b10, 1'b1, 4'd2, 3, 64'h0000_0000_BEEF_BEEF, shadow[3] ^ 64'h1, "R7 cas miss");
      issue(2'b10, 1'b0, 4'd2, 4, 64'h0000_0000_1357_9BDF,
            {~shadow[4][63:32], shadow[4][31:0]}, "R9 narrow cas low-half match");
      issue(2'b10, 1'b1, 4'd6, 5, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0, "R8 smin");
      issue(2'b10, 1'b1, 4'd7, 5, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0, "R8 umin");
      issue(2'b10, 1'b1, 4'd8, 6, 64'h7FFF_FFFF_0000_0000, 64'h0, "R8 smax");
      issue(2'b10, 1'b1, 4'd9, 6, 64'h0000_0000_0000_0003, 64'h0, "R8 umax");
      issue(2'b10, 1'b0, 4'd6, 7, 64'h0000_0000_8000_0000, 64'h0, "R8 narrow smin");
      issue(2'b10, 1'b0, 4'd9, 7, 64'hFFFF_FFFF_0000_0002, 64'h0, "R8 narrow umax");
      issue(2'b10, 1'b1, 4'd12, 0, 64'h1234_1234_1234_1234, 64'h0, "R10 undefined op");
      issue(2'b11, 1'b0, 4'd15, 1, 64'h5, 64'h0, "R10 undefined op kind 11");
      issue(2'b11, 1'b1, 4'd0, 2, 64'h10, 64'h0, "R5 kind 11 atomic");

      for (int k = 0; k < 40; k++) begin
         logic [1:0]  kd;
         logic [63:0] ra, rb;
         int          ix;
         kd = (k % 5 == 0) ? 2'b00 : ((k % 7 == 0) ? 2'b01 : 2'b10);
         ix = k % 8;
         ra = {$urandom, $urandom};
         rb = (k % 3 == 0) ? shadow[ix] : {$urandom, $urandom};
         issue(kd, k[0], 4'(k % 11), ix, ra, rb, "R5 mixed stream");
      end

      while (exp_q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule